// File: doc/BRIEF.md
# Shared and Per-Core Interrupt Router with Pending Selector

This block decides, for every core context in a cluster, which interrupt that core should service next. Each shared interrupt line carries a routing entry that names exactly one destination core, and a second entry that holds an output pin number together with a valid flag. A register write port fills both tables. The sense logic upstream delivers the pending and mask vectors for the shared lines, plus pending and mask bits for a few local sources that belong to each core.

For every core the block forms the set of candidates and reports the winner on a per-core index output. Local sources of that core take precedence over shared lines. Among the shared lines, only those that are pending, unmasked and routed to that core count. In each group the lowest-numbered candidate wins. Indices form one space: local source k is reported as k, shared line i as NUM_LOCAL+i, and NUM_LOCAL+NUM_SHARED means that nothing is selected. A per-core request line is raised whenever a candidate exists. A read port returns the routing entries of one line, and a constant configuration word reports the line and core counts.

Top module: `irq_route_sel`

## Requirements
- R1: After reset every shared line is routed to core 0, and every pin entry reads as valid=0, pin=0.
- R2: A write with wrEn=1 and wrKind=0 routes line wrLine to the core whose number is in wrData[CORE_W-1:0]. The new destination replaces the previous one, so the line always has exactly one destination. The change is visible from the cycle after the write edge.
- R3: A write with wrEn=1 and wrKind=1 stores the pin entry of line wrLine. wrData[PIN_W] is the valid flag and wrData[PIN_W-1:0] is the pin number. The entry reads back on rdPin in the same bit positions.
- R4: A write whose line number is not below NUM_SHARED, or a route write whose core number is not below NUM_CORES, changes no table entry.
- R5: The shared candidates of core c are pendShared AND maskShared AND (lines routed to c). The lowest candidate line i is reported as NUM_LOCAL+i.
- R6: Local source k of core c uses bit c*NUM_LOCAL+k of localPend and localMask. If any local source of core c is both pending and unmasked, the lowest such k is reported and shared lines are ignored.
- R7: With no candidate, the index of core c equals NUM_LOCAL+NUM_SHARED.
- R8: irqReq[c] is high exactly when core c has a local or shared candidate.
- R9: cfgWord[15:8] equals NUM_SHARED/8-1 and cfgWord[7:0] equals NUM_CORES-1.
- R10: The selection is combinational: a change of the pending or mask inputs shows on selIdx and irqReq in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendShared | input | NUM_SHARED | Pending bits of the shared lines |
| maskShared | input | NUM_SHARED | Enable bits of the shared lines (1 = unmasked) |
| localPend | input | NUM_CORES*NUM_LOCAL | Pending bits of the local sources, grouped by core |
| localMask | input | NUM_CORES*NUM_LOCAL | Enable bits of the local sources, grouped by core |
| wrEn | input | 1 | Table write strobe |
| wrKind | input | 1 | 0 = write the route entry, 1 = write the pin entry |
| wrLine | input | LINE_W | Line number of the write |
| wrData | input | DATA_W | Core number or {valid, pin} |
| rdLine | input | LINE_W | Line number read back |
| rdCore | output | NUM_CORES | One-hot destination of rdLine (zero if the line does not exist) |
| rdPin | output | PIN_W+1 | {valid, pin} of rdLine |
| cfgWord | output | 16 | Shared-line and core count fields |
| irqReq | output | NUM_CORES | Per-core request |
| selIdx | output | NUM_CORES*IDX_W | Per-core selected index, core c in bits c*IDX_W upward |

## Verification
The selection results and the read port are combinational, so they are due in the same cycle as their stimulus. The bench changes pending and mask inputs on a falling edge and samples one time unit later, with no clock edge in between. Route and pin writes take one rising edge. The bench presents a write on a falling edge, lets the next rising edge commit it, and checks rdCore, rdPin and the selections on the falling edge that follows. Ignored writes are checked the same way, by reading back the entries they could have altered.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Write strobes that the control passes to the datapath
  typedef struct packed {
    logic routeWr;
    logic pinWr;
  } tblStrobe_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SHARED = 24,
  parameter int NUM_CORES  = 3,
  parameter int LINE_W     = 5,
  parameter int CORE_W     = 2,
  parameter int DATA_W     = 4
) (
  input  logic              wrEn,
  input  logic              wrKind,
  input  logic [LINE_W-1:0] wrLine,
  input  logic [DATA_W-1:0] wrData,
  output tblStrobe_t        strobe
);

  logic lineOk;
  logic coreOk;

  always_comb begin
    lineOk = int'(wrLine) < NUM_SHARED;
    coreOk = int'(wrData[CORE_W-1:0]) < NUM_CORES;
    strobe.routeWr = wrEn && !wrKind && lineOk && coreOk;
    strobe.pinWr   = wrEn &&  wrKind && lineOk;
  end

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_SHARED = 24,
  parameter int NUM_CORES  = 3,
  parameter int NUM_LOCAL  = 3,
  parameter int PIN_W      = 3,
  parameter int LINE_W     = 5,
  parameter int CORE_W     = 2,
  parameter int DATA_W     = 4,
  parameter int IDX_W      = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  tblStrobe_t                     strobe,
  input  logic [LINE_W-1:0]              wrLine,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_SHARED-1:0]          pendShared,
  input  logic [NUM_SHARED-1:0]          maskShared,
  input  logic [NUM_CORES*NUM_LOCAL-1:0] localPend,
  input  logic [NUM_CORES*NUM_LOCAL-1:0] localMask,
  input  logic [LINE_W-1:0]              rdLine,
  output logic [NUM_CORES-1:0]           rdCore,
  output logic [PIN_W:0]                 rdPin,
  output logic [NUM_CORES-1:0]           irqReq,
  output logic [NUM_CORES*IDX_W-1:0]     selIdx
);

  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NUM_LOCAL + NUM_SHARED);

  logic [NUM_CORES-1:0] routeTbl [NUM_SHARED];
  logic [PIN_W:0]       pinTbl   [NUM_SHARED];

  // Routing tables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SHARED; i++) begin
        routeTbl[i] <= NUM_CORES'(1);
        pinTbl[i]   <= '0;
      end
    end else begin
      if (strobe.routeWr)
        routeTbl[wrLine] <= NUM_CORES'(1) << wrData[CORE_W-1:0];
      if (strobe.pinWr)
        pinTbl[wrLine] <= wrData[PIN_W:0];
    end
  end

  // Read-back port
  logic              rdOk;
  logic [LINE_W-1:0] rdSafe;

  always_comb begin
    rdOk   = int'(rdLine) < NUM_SHARED;
    rdSafe = rdOk ? rdLine : '0;
    rdCore = rdOk ? routeTbl[rdSafe] : '0;
    rdPin  = rdOk ? pinTbl[rdSafe]   : '0;
  end

  // Per-core selectors
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_SHARED-1:0] shCand;
    logic [NUM_LOCAL-1:0]  lcCand;
    logic [IDX_W-1:0]      lcIdx;
    logic [IDX_W-1:0]      shIdx;

    always_comb begin
      for (int i = 0; i < NUM_SHARED; i++)
        shCand[i] = pendShared[i] & maskShared[i] & routeTbl[i][c];
      lcCand = localPend[c*NUM_LOCAL +: NUM_LOCAL] &
               localMask[c*NUM_LOCAL +: NUM_LOCAL];

      lcIdx = '0;
      for (int k = NUM_LOCAL - 1; k >= 0; k--)
        if (lcCand[k]) lcIdx = IDX_W'(k);

      shIdx = '0;
      for (int i = NUM_SHARED - 1; i >= 0; i--)
        if (shCand[i]) shIdx = IDX_W'(NUM_LOCAL + i);

      irqReq[c] = (|lcCand) | (|shCand);
      if (|lcCand)
        selIdx[c*IDX_W +: IDX_W] = lcIdx;
      else if (|shCand)
        selIdx[c*IDX_W +: IDX_W] = shIdx;
      else
        selIdx[c*IDX_W +: IDX_W] = NONE_IDX;
    end
  end

endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
  import irq_route_pkg::*;
#(
  parameter int NUM_SHARED = 24,
  parameter int NUM_CORES  = 3,
  parameter int NUM_LOCAL  = 3,
  parameter int PIN_W      = 3,
  localparam int LINE_W    = $clog2(NUM_SHARED),
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int DATA_W    = (CORE_W > PIN_W + 1) ? CORE_W : PIN_W + 1,
  localparam int IDX_W     = $clog2(NUM_LOCAL + NUM_SHARED + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SHARED-1:0]          pendShared,
  input  logic [NUM_SHARED-1:0]          maskShared,
  input  logic [NUM_CORES*NUM_LOCAL-1:0] localPend,
  input  logic [NUM_CORES*NUM_LOCAL-1:0] localMask,
  input  logic                           wrEn,
  input  logic                           wrKind,
  input  logic [LINE_W-1:0]              wrLine,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [LINE_W-1:0]              rdLine,
  output logic [NUM_CORES-1:0]           rdCore,
  output logic [PIN_W:0]                 rdPin,
  output logic [15:0]                    cfgWord,
  output logic [NUM_CORES-1:0]           irqReq,
  output logic [NUM_CORES*IDX_W-1:0]     selIdx
);

  tblStrobe_t strobe;

  assign cfgWord = {8'(NUM_SHARED / 8 - 1), 8'(NUM_CORES - 1)};

  irq_route_ctrl #(
    .NUM_SHARED(NUM_SHARED), .NUM_CORES(NUM_CORES),
    .LINE_W(LINE_W), .CORE_W(CORE_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .wrEn(wrEn), .wrKind(wrKind), .wrLine(wrLine), .wrData(wrData),
    .strobe(strobe)
  );

  irq_route_dp #(
    .NUM_SHARED(NUM_SHARED), .NUM_CORES(NUM_CORES), .NUM_LOCAL(NUM_LOCAL),
    .PIN_W(PIN_W), .LINE_W(LINE_W), .CORE_W(CORE_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrLine(wrLine), .wrData(wrData),
    .pendShared(pendShared), .maskShared(maskShared),
    .localPend(localPend), .localMask(localMask),
    .rdLine(rdLine), .rdCore(rdCore), .rdPin(rdPin),
    .irqReq(irqReq), .selIdx(selIdx)
  );

endmodule

// File: rtl/irq_route_sel_chk.sv
module irq_route_sel_chk #(
  parameter int NUM_SHARED = 24,
  parameter int NUM_CORES  = 3,
  parameter int NUM_LOCAL  = 3,
  parameter int LINE_W     = 5,
  parameter int IDX_W      = 5
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_SHARED-1:0]          pendShared,
  input logic [NUM_SHARED-1:0]          maskShared,
  input logic [NUM_CORES*NUM_LOCAL-1:0] localPend,
  input logic [NUM_CORES*NUM_LOCAL-1:0] localMask,
  input logic [LINE_W-1:0]              rdLine,
  input logic [NUM_CORES-1:0]           rdCore,
  input logic [NUM_CORES-1:0]           irqReq,
  input logic [NUM_CORES*IDX_W-1:0]     selIdx
);

  localparam int NONE = NUM_LOCAL + NUM_SHARED;

  // R2: an existing line always has exactly one destination
  assert_single_dest_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdLine) < NUM_SHARED) |-> ($countones(rdCore) == 1));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic [IDX_W-1:0]     sel;
    logic [NUM_LOCAL-1:0] lc;
    assign sel = selIdx[c*IDX_W +: IDX_W];
    assign lc  = localPend[c*NUM_LOCAL +: NUM_LOCAL] &
                 localMask[c*NUM_LOCAL +: NUM_LOCAL];

    assert_req_vs_index_R8: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[c] == (int'(sel) != NONE));

    assert_local_first_R6: assert property (@(posedge clk) disable iff (!rstN)
      (lc != '0) |-> (int'(sel) < NUM_LOCAL));

    assert_none_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
      (int'(sel) == NONE) |-> (lc == '0));

    assert_shared_live_R5: assert property (@(posedge clk) disable iff (!rstN)
      (int'(sel) >= NUM_LOCAL && int'(sel) < NONE) |->
        (pendShared[int'(sel) - NUM_LOCAL] && maskShared[int'(sel) - NUM_LOCAL]));
  end

endmodule

bind irq_route_sel irq_route_sel_chk #(
  .NUM_SHARED(NUM_SHARED), .NUM_CORES(NUM_CORES), .NUM_LOCAL(NUM_LOCAL),
  .LINE_W(LINE_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pendShared(pendShared), .maskShared(maskShared),
  .localPend(localPend), .localMask(localMask), .rdLine(rdLine),
  .rdCore(rdCore), .irqReq(irqReq), .selIdx(selIdx)
);

// File: tb/irq_route_sel_bench.sv
module irq_route_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 24;
  localparam int NC = 3;
  localparam int NL = 3;
  localparam int PW = 3;
  localparam int LW = 5;
  localparam int DW = 4;
  localparam int IW = 5;
  localparam int NONE = NL + NS;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NS-1:0]     pendShared = '0;
  logic [NS-1:0]     maskShared = '0;
  logic [NC*NL-1:0]  localPend = '0;
  logic [NC*NL-1:0]  localMask = '0;
  logic              wrEn = 1'b0;
  logic              wrKind = 1'b0;
  logic [LW-1:0]     wrLine = '0;
  logic [DW-1:0]     wrData = '0;
  logic [LW-1:0]     rdLine = '0;
  logic [NC-1:0]     rdCore;
  logic [PW:0]       rdPin;
  logic [15:0]       cfgWord;
  logic [NC-1:0]     irqReq;
  logic [NC*IW-1:0]  selIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_sel #(.NUM_SHARED(NS), .NUM_CORES(NC), .NUM_LOCAL(NL), .PIN_W(PW))
  u_irq_route_sel (
    .clk(clk), .rstN(rstN), .pendShared(pendShared), .maskShared(maskShared),
    .localPend(localPend), .localMask(localMask), .wrEn(wrEn), .wrKind(wrKind),
    .wrLine(wrLine), .wrData(wrData), .rdLine(rdLine), .rdCore(rdCore),
    .rdPin(rdPin), .cfgWord(cfgWord), .irqReq(irqReq), .selIdx(selIdx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sel(input int c);
    return int'(selIdx[c*IW +: IW]);
  endfunction

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic writeTbl(input bit kind, input int line, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrKind = kind; wrLine = LW'(line); wrData = DW'(data);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic readCore(input int line, input string req, input int exp);
    rdLine = LW'(line);
    #1;
    chk(req, int'(rdCore), exp);
  endtask

  task automatic t_reset();
    settle();
    readCore(0, "R1 route line0", 1);
    readCore(23, "R1 route line23", 1);
    rdLine = LW'(23); #1;
    chk("R1 pin line23", int'(rdPin), 0);
    chk("R9 cfg word", int'(cfgWord), 16'h0202);
    for (int c = 0; c < NC; c++) begin
      chk("R7 idle index", sel(c), NONE);
      chk("R8 idle request", int'(irqReq[c]), 0);
    end
  endtask

  task automatic t_shared();
    settle();
    pendShared = (NS'(1) << 5) | (NS'(1) << 9);
    maskShared = '1;
    #1;
    chk("R10 R5 lowest to core0", sel(0), NL + 5);
    chk("R8 core0 request", int'(irqReq[0]), 1);
    chk("R5 core1 none", sel(1), NONE);
    maskShared[5] = 1'b0;
    #1;
    chk("R5 masked line skipped", sel(0), NL + 9);
    pendShared = '0;
    #1;
    chk("R7 nothing pending", sel(0), NONE);
    chk("R8 request drops", int'(irqReq[0]), 0);
  endtask

  task automatic t_route();
    pendShared = NS'(1) << 9;
    maskShared = '1;
    writeTbl(1'b0, 9, 2);
    readCore(9, "R2 route to core2", 4);
    chk("R2 core2 selects", sel(2), NL + 9);
    chk("R5 core0 loses line", sel(0), NONE);
    writeTbl(1'b0, 9, 1);
    readCore(9, "R2 route replaced", 2);
    chk("R2 core1 selects", sel(1), NL + 9);
    chk("R2 core2 released", sel(2), NONE);
    pendShared = (NS'(1) << 9) | (NS'(1) << 23);
    writeTbl(1'b0, 23, 1);
    chk("R5 lower line wins", sel(1), NL + 9);
    pendShared = NS'(1) << 23;
    #1;
    chk("R5 top line index", sel(1), NL + 23);
    pendShared = '0;
  endtask

  task automatic t_pin();
    writeTbl(1'b1, 7, 4'b1101);
    rdLine = LW'(7); #1;
    chk("R3 pin entry", int'(rdPin), 4'b1101);
    writeTbl(1'b1, 7, 4'b0010);
    chk("R3 pin rewrite", int'(rdPin), 4'b0010);
  endtask

  task automatic t_ignore();
    writeTbl(1'b0, 4, 3);
    readCore(4, "R4 core3 ignored", 1);
    writeTbl(1'b0, 30, 2);
    readCore(6, "R4 line30 no alias6", 1);
    readCore(14, "R4 line30 no alias14", 1);
    readCore(30, "R4 absent line reads zero", 0);
    writeTbl(1'b1, 30, 4'b1111);
    rdLine = LW'(6); #1;
    chk("R4 pin write ignored", int'(rdPin), 0);
  endtask

  task automatic t_local();
    settle();
    pendShared = NS'(1) << 9;   // routed to core1
    maskShared = '1;
    localPend[1*NL + 2] = 1'b1;
    localMask[1*NL + 2] = 1'b1;
    #1;
    chk("R6 local beats shared", sel(1), 2);
    localMask[1*NL + 2] = 1'b0;
    #1;
    chk("R6 masked local falls through", sel(1), NL + 9);
    localMask = '1;
    localPend[1*NL + 0] = 1'b1;
    #1;
    chk("R6 lowest local wins", sel(1), 0);
    chk("R6 other core unaffected", sel(0), NONE);
    pendShared = '0;
    localPend = '0;
    localPend[2*NL + 1] = 1'b1;
    #1;
    chk("R6 local of core2", sel(2), 1);
    chk("R8 core2 request local", int'(irqReq[2]), 1);
    localPend = '0;
    #1;
    chk("R8 core2 request off", int'(irqReq[2]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_shared();
    t_route();
    t_pin();
    t_ignore();
    t_local();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule